// File: doc/BRIEF.md
# Configurable CAN Identifier Acceptance Filter

This block judges whether the identifier of a just-received CAN frame should be let through. It keeps one bank of eight code bytes and eight mask bytes. A two-bit mode field decides how that bank is used. It can act as two filters of 32 bits, four filters of 16 bits or eight filters of 8 bits, all compared in parallel. It can also be shut so that nothing passes. The receive path presents the first four identifier bytes together with a one-cycle strobe. One clock later the block raises a one-cycle accept pulse and stores the index of the winning filter in a status field. The bank and the mode are loaded through a simple byte-wide write port.

Control is a small state machine with three states. ST_CONFIG is entered at reset and whenever soft reset is held. ST_RUN is the normal state when a filtering mode is set. ST_CLOSED is used when the shut mode is set. The transitions are: ST_CONFIG to ST_RUN when soft reset is low and the mode is not shut. ST_CONFIG to ST_CLOSED when soft reset is low and the mode is shut. ST_RUN or ST_CLOSED back to ST_CONFIG when soft reset is high. A strobe is judged only in ST_RUN.

Top module: `can_id_filter`

## Requirements
- R1: After hard reset the mode field is 00, the hit field is 0 and accept is low.
- R2: A mask bit of 1 makes the matching identifier bit a don't-care. A mask bit of 0 requires the identifier bit to equal the code bit.
- R3: In mode 00 there are two filters. Filter f compares identifier byte k (id_bytes[8k+7:8k], k=0..3) with code and mask byte 4f+k. The hit index is 0 or 1.
- R4: In mode 01 there are four filters. Filter f compares identifier bytes 0 and 1 with code and mask bytes 2f and 2f+1.
- R5: In mode 10 there are eight filters. Filter f compares identifier byte 0 with code and mask byte f.
- R6: In mode 11 no strobe is ever accepted.
- R7: When several filters match, the lowest-numbered one is reported in the hit field.
- R8: The hit field changes only on an accept or a soft reset. A rejected strobe leaves it unchanged.
- R9: Accept goes high in the cycle after the clock edge that samples the strobe. It stays high for exactly one cycle per strobe.
- R10: Write address 0..7 loads code byte 0..7. Address 8..15 loads mask byte 0..7. Address 16 loads the mode from wr_data[1:0]. A mode write is ignored unless soft_rst is high.
- R11: While soft_rst is high, strobes are ignored and the hit field is cleared to 0. Strobes are also ignored on the edge at which soft reset is released.
- R12: If a code or mask write lands on the same edge as a strobe, that strobe is judged with the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Holds the filter in configuration state |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| id_valid | input | 1 | Identifier strobe, one cycle per frame |
| id_bytes | input | 32 | First four identifier bytes, byte k at [8k+7:8k] |
| accept | output | 1 | One-cycle accept pulse |
| hit_idx | output | 3 | Index of the last accepting filter |
| mode_o | output | 2 | Current mode field |

## Verification
Two kinds of event can fall on the same clock edge as an identifier strobe.

- **Storage write.** A code or mask write can land on the strobe's edge. The bench forces this by writing a code byte that breaks the match on that very edge. It expects the strobe to still be judged with the old contents, which means an accept. It then sends a second strobe and expects a reject.
- **Soft reset.** Soft reset can be asserted on the strobe's edge, with an identifier that would otherwise match. The bench expects no accept and a cleared hit field.

The bench also checks that a mode write made outside soft reset leaves the mode unchanged.

// File: rtl/can_idf_pkg.sv
package can_idf_pkg;

    typedef enum logic [1:0] {
        MODE_W32  = 2'b00,
        MODE_W16  = 2'b01,
        MODE_W8   = 2'b10,
        MODE_SHUT = 2'b11
    } acc_mode_e;

    typedef enum logic [1:0] {
        ST_CONFIG = 2'b00,
        ST_RUN    = 2'b01,
        ST_CLOSED = 2'b10
    } flt_state_e;

endpackage

// File: rtl/can_idf_regs.sv
module can_idf_regs
    import can_idf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 8,
    parameter int ADDR_W     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [BANK_BYTES*DATA_W-1:0] code_o,
    output logic [BANK_BYTES*DATA_W-1:0] mask_o,
    output acc_mode_e                    mode_o
);
    localparam int MASK_BASE = BANK_BYTES;
    localparam int CTRL_ADDR = 2 * BANK_BYTES;

    for (genvar p = 0; p < BANK_BYTES; p++) begin : g_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_o[p*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(p)) begin
                code_o[p*DATA_W +: DATA_W] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mask_o[p*DATA_W +: DATA_W] <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(MASK_BASE + p)) begin
                mask_o[p*DATA_W +: DATA_W] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o <= MODE_W32;
        end else if (wr_en && soft_rst && wr_addr == ADDR_W'(CTRL_ADDR)) begin
            mode_o <= acc_mode_e'(wr_data[1:0]);
        end
    end

endmodule

// File: rtl/can_idf_match.sv
module can_idf_match
    import can_idf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 8,
    parameter int ID_BYTES   = 4
) (
    input  logic [BANK_BYTES*DATA_W-1:0] code_i,
    input  logic [BANK_BYTES*DATA_W-1:0] mask_i,
    input  logic [ID_BYTES*DATA_W-1:0]   id_i,
    input  acc_mode_e                    mode_i,
    output logic [BANK_BYTES-1:0]        hit_vec_o
);
    localparam int G32 = BANK_BYTES / 4;
    localparam int G16 = BANK_BYTES / 2;

    logic [BANK_BYTES-1:0] byte_ok;
    logic [BANK_BYTES-1:0] f32;
    logic [BANK_BYTES-1:0] f16;

    for (genvar p = 0; p < BANK_BYTES; p++) begin : g_cmp
        logic [DATA_W-1:0] id_sel;
        logic [DATA_W-1:0] diff;
        always_comb begin
            unique case (mode_i)
                MODE_W32: id_sel = id_i[(p % 4) * DATA_W +: DATA_W];
                MODE_W16: id_sel = id_i[(p % 2) * DATA_W +: DATA_W];
                default:  id_sel = id_i[0 +: DATA_W];
            endcase
            diff       = (code_i[p*DATA_W +: DATA_W] ^ id_sel) & ~mask_i[p*DATA_W +: DATA_W];
            byte_ok[p] = (diff == '0);
        end
    end

    for (genvar f = 0; f < BANK_BYTES; f++) begin : g_grp
        if (f < G32) begin : g_w32
            assign f32[f] = &byte_ok[4*f +: 4];
        end else begin : g_w32_off
            assign f32[f] = 1'b0;
        end
        if (f < G16) begin : g_w16
            assign f16[f] = &byte_ok[2*f +: 2];
        end else begin : g_w16_off
            assign f16[f] = 1'b0;
        end
    end

    always_comb begin
        unique case (mode_i)
            MODE_W32: hit_vec_o = f32;
            MODE_W16: hit_vec_o = f16;
            MODE_W8:  hit_vec_o = byte_ok;
            default:  hit_vec_o = '0;
        endcase
    end

endmodule

// File: rtl/can_idf_prio.sv
module can_idf_prio #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                idx_o = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_idf_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int BANK_BYTES = 8,
    parameter int ID_BYTES   = 4,
    parameter int ADDR_W     = $clog2(2 * BANK_BYTES + 1),
    parameter int HIT_W      = $clog2(BANK_BYTES)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_rst,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       id_valid,
    input  logic [ID_BYTES*DATA_W-1:0] id_bytes,
    output logic                       accept,
    output logic [HIT_W-1:0]           hit_idx,
    output logic [1:0]                 mode_o
);
    logic [BANK_BYTES*DATA_W-1:0] code_w;
    logic [BANK_BYTES*DATA_W-1:0] mask_w;
    acc_mode_e                    mode_w;
    logic [BANK_BYTES-1:0]        hit_vec;
    logic                         any_hit;
    logic [HIT_W-1:0]             win_idx;
    flt_state_e                   state_q, state_d;

    can_idf_regs #(
        .DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .code_o(code_w), .mask_o(mask_w), .mode_o(mode_w)
    );

    can_idf_match #(
        .DATA_W(DATA_W), .BANK_BYTES(BANK_BYTES), .ID_BYTES(ID_BYTES)
    ) u_match (
        .code_i(code_w), .mask_i(mask_w), .id_i(id_bytes),
        .mode_i(mode_w), .hit_vec_o(hit_vec)
    );

    can_idf_prio #(
        .N(BANK_BYTES), .IDX_W(HIT_W)
    ) u_prio (
        .req_i(hit_vec), .any_o(any_hit), .idx_o(win_idx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONFIG: if (!soft_rst) state_d = (mode_w == MODE_SHUT) ? ST_CLOSED : ST_RUN;
            ST_RUN:    if (soft_rst)  state_d = ST_CONFIG;
            ST_CLOSED: if (soft_rst)  state_d = ST_CONFIG;
            default:   state_d = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            accept  <= 1'b0;
            hit_idx <= '0;
        end else if (soft_rst) begin
            accept  <= 1'b0;
            hit_idx <= '0;
        end else if (state_q == ST_RUN && id_valid && any_hit) begin
            accept  <= 1'b1;
            hit_idx <= win_idx;
        end else begin
            accept  <= 1'b0;
        end
    end

    assign mode_o = mode_w;

endmodule

// File: rtl/can_idf_checker.sv
module can_idf_checker #(
    parameter int HIT_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             soft_rst,
    input logic             id_valid,
    input logic             accept,
    input logic [HIT_W-1:0] hit_idx,
    input logic [1:0]       mode_o
);
    assert_accept_follows_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(id_valid));

    assert_closed_never_accepts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_o) == 2'b11) |-> !accept);

    assert_hit_held_on_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!accept && !$past(soft_rst)) |-> (hit_idx == $past(hit_idx)));

    assert_mode_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(soft_rst) |-> $stable(mode_o));

    assert_soft_reset_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (!accept && hit_idx == '0));

    assert_w32_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_o == 2'b00) |-> (hit_idx < 2));

    assert_w16_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && mode_o == 2'b01) |-> (hit_idx < 4));
endmodule

bind can_id_filter can_idf_checker #(.HIT_W(HIT_W)) u_idf_chk (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .id_valid(id_valid),
    .accept(accept), .hit_idx(hit_idx), .mode_o(mode_o)
);

// File: tb/can_id_filter_bench.sv
module can_id_filter_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_rst = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        id_valid = 1'b0;
    logic [31:0] id_bytes = '0;
    logic        accept;
    logic [2:0]  hit_idx;
    logic [1:0]  mode_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_code [8];
    logic [7:0] m_mask [8];
    logic [1:0] m_mode;
    logic [2:0] m_hit;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_id_filter u_can_id_filter (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .id_valid(id_valid),
        .id_bytes(id_bytes), .accept(accept), .hit_idx(hit_idx), .mode_o(mode_o)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] exp_match(logic [31:0] id);
        logic [7:0] v = '0;
        for (int f = 0; f < 8; f++) begin
            logic ok = 1'b1;
            case (m_mode)
                2'b00: begin
                    if (f >= 2) ok = 1'b0;
                    else for (int k = 0; k < 4; k++)
                        if (((m_code[4*f+k] ^ id[8*k +: 8]) & ~m_mask[4*f+k]) != 0) ok = 1'b0;
                end
                2'b01: begin
                    if (f >= 4) ok = 1'b0;
                    else for (int k = 0; k < 2; k++)
                        if (((m_code[2*f+k] ^ id[8*k +: 8]) & ~m_mask[2*f+k]) != 0) ok = 1'b0;
                end
                2'b10: if (((m_code[f] ^ id[7:0]) & ~m_mask[f]) != 0) ok = 1'b0;
                default: ok = 1'b0;
            endcase
            v[f] = ok;
        end
        return v;
    endfunction

    function automatic logic [2:0] lowest(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return 3'(i);
        return 3'd0;
    endfunction

    task automatic write_reg(logic [4:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (a < 8) m_code[a] = d;
        else if (a < 16) m_mask[a-8] = d;
        else if (a == 16 && soft_rst) m_mode = d[1:0];
    endtask

    task automatic set_mode(logic [1:0] m);
        soft_rst = 1'b1;
        write_reg(5'd16, {6'd0, m});
        m_hit = '0;
        soft_rst = 1'b0;
        repeat (2) @(posedge clk);
        #1 chk("R10", mode_o, m);
    endtask

    task automatic strobe(logic [31:0] id, string req);
        logic [7:0] mv;
        logic       exp_acc;
        @(negedge clk);
        id_valid = 1'b1; id_bytes = id;
        mv = exp_match(id);
        exp_acc = (mv != 0);
        if (exp_acc) m_hit = lowest(mv);
        @(posedge clk); #1;
        id_valid = 1'b0;
        chk(req, accept, exp_acc);
        chk(req, hit_idx, m_hit);
    endtask

    function automatic logic [31:0] near_id();
        logic [31:0] id = $urandom;
        int f = $urandom % 8;
        if ($urandom % 4 != 0) begin
            case (m_mode)
                2'b00: for (int k = 0; k < 4; k++)
                    id[8*k +: 8] = m_code[4*(f%2)+k] ^ (8'($urandom) & m_mask[4*(f%2)+k]);
                2'b01: for (int k = 0; k < 2; k++)
                    id[8*k +: 8] = m_code[2*(f%4)+k] ^ (8'($urandom) & m_mask[2*(f%4)+k]);
                default: id[7:0] = m_code[f] ^ (8'($urandom) & m_mask[f]);
            endcase
        end
        if ($urandom % 5 == 0) id = id ^ (32'd1 << ($urandom % 32));
        return id;
    endfunction

    task automatic random_bank();
        for (int p = 0; p < 8; p++) write_reg(5'(p), 8'($urandom));
        for (int p = 0; p < 8; p++) write_reg(5'(8 + p), 8'($urandom) & 8'($urandom));
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5EED_CA11);
        for (int p = 0; p < 8; p++) begin m_code[p] = '0; m_mask[p] = '0; end
        m_mode = 2'b00; m_hit = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", accept, 0); chk("R1", hit_idx, 0); chk("R1", mode_o, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        write_reg(5'd16, 8'h02);
        #1 chk("R10", mode_o, 2'b00);

        // mode 00 directed
        write_reg(0, 8'h11); write_reg(1, 8'h22); write_reg(2, 8'h33); write_reg(3, 8'h44);
        write_reg(4, 8'hA1); write_reg(5, 8'hB2); write_reg(6, 8'hC3); write_reg(7, 8'hD4);
        strobe(32'h44332211, "R3");
        strobe(32'hD4C3B2A1, "R3");
        strobe(32'h00000000, "R8");
        @(posedge clk); #1 chk("R9", accept, 0);
        write_reg(8, 8'h0F);
        strobe(32'h4433221E, "R2");
        strobe(32'h443322E1, "R2");
        for (int p = 12; p < 16; p++) write_reg(5'(p), 8'hFF);
        strobe(32'h44332211, "R7");
        strobe(32'h12345678, "R7");

        // same-edge write and strobe: old contents apply
        write_reg(8, 8'h00);
        for (int p = 12; p < 16; p++) write_reg(5'(p), 8'h00);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd0; wr_data = 8'h99;
        id_valid = 1'b1; id_bytes = 32'h44332211;
        @(posedge clk); #1;
        wr_en = 1'b0; id_valid = 1'b0; m_code[0] = 8'h99; m_hit = 3'd0;
        chk("R12", accept, 1); chk("R12", hit_idx, 0);
        strobe(32'h44332211, "R12");

        // soft reset on the strobe edge
        strobe(32'hD4C3B2A1, "R3");
        @(negedge clk);
        soft_rst = 1'b1; id_valid = 1'b1; id_bytes = 32'hD4C3B2A1;
        @(posedge clk); #1;
        id_valid = 1'b0; m_hit = '0;
        chk("R11", accept, 0); chk("R11", hit_idx, 0);
        soft_rst = 1'b0;
        repeat (2) @(posedge clk);

        // random sweeps in every mode
        for (int m = 0; m < 4; m++) begin
            set_mode(2'(m));
            for (int b = 0; b < 6; b++) begin
                random_bank();
                for (int n = 0; n < 60; n++) begin
                    case (m)
                        0: strobe(near_id(), "R3");
                        1: strobe(near_id(), "R4");
                        2: strobe(near_id(), "R5");
                        default: strobe(near_id(), "R6");
                    endcase
                end
            end
        end

        // closed mode with wide-open masks still rejects
        for (int p = 8; p < 16; p++) write_reg(5'(p), 8'hFF);
        strobe(32'h0, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule